// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit sits between instruction decode and the load/store path of a small 16-bit processor core. For each instruction it takes the decoded addressing-mode code, the 8-bit address field, a 3-bit register number, the contents of all eight general registers, the program counter and the stack pointer. It then returns one of two things. It gives an immediate operand, or a register operand, with `is_operand` high. Otherwise it gives an effective address with `is_operand` low. A one-cycle `done` strobe marks the result.

Most modes are pure arithmetic, and the unit finishes them in the same cycle as `start`. Three modes need a pointer word from memory: plain indirect, preindexed indirect and postindexed indirect. For these the unit issues one read on a request/acknowledge port and finishes one cycle after the acknowledge. Push and pop also hand back the updated stack pointer on a write strobe that comes with `done`.

The sequencer has three states. IDLE is the only state that accepts `start`. IDLE moves to PTR_WAIT when a memory mode starts, and stays in IDLE for any other mode. PTR_WAIT holds the request and stays in place until `mem_ack`, then moves to RESOLVE. RESOLVE presents the result for one cycle and always returns to IDLE.

Top module: `addr_mode_unit`

## Requirements
- R1: Mode code 0 (immediate) gives `result` = address field sign-extended from bit 7 to 16 bits, with `is_operand`=1 and `done`=1 in the same cycle as `start`, and no memory request.
- R2: Mode code 1 (direct) gives `result` = address field zero-extended, with `is_operand`=0 and `done` in the `start` cycle.
- R3: Mode code 2 (indirect) raises `mem_req` with `mem_addr` = zero-extended address field in the cycle after `start`. The word returned with `mem_ack` becomes `result`, and `done` rises exactly one cycle after the acknowledge cycle.
- R4: Mode code 3 (register) returns register `reg_sel` as an operand (`is_operand`=1). Mode code 4 (register indirect) returns the same register contents as an address (`is_operand`=0). Register n occupies bits [16n+15:16n] of `reg_bank`. Both modes finish in the `start` cycle.
- R5: Mode code 5 (PC-relative) gives `result` = `pc` + sign-extended address field.
- R6: Mode code 6 (base) gives register + sign-extended address field. Mode code 7 (indexed) gives zero-extended address field + register.
- R7: Mode code 8 (preindexed indirect) reads memory at zero-extended address field + register, and the returned word is `result`.
- R8: Mode code 9 (postindexed indirect) reads memory at the zero-extended address field, and `result` = returned word + register.
- R9: Mode code 10 (push) gives `result` = `sp` − 1 and pulses `sp_we` with `sp_wdata` = `sp` − 1 in the `done` cycle, wrapping modulo 2^16.
- R10: Mode code 11 (pop) gives `result` = `sp` and pulses `sp_we` with `sp_wdata` = `sp` + 1 in the `done` cycle.
- R11: Mode codes 12 to 15 raise `illegal` together with `done` in the `start` cycle. They cause no memory request and no stack pointer write.
- R12: While a pointer read is pending, `mem_req` and `mem_addr` hold steady until `mem_ack`. A `start` during that time is ignored and produces no `done`.
- R13: After reset `done`, `mem_req` and `sp_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one address computation (accepted in IDLE) |
| mode | input | 4 | Addressing-mode code |
| addr_fld | input | 8 | Address / displacement / immediate field |
| reg_sel | input | 3 | Register number |
| reg_bank | input | 128 | Contents of the eight general registers, register n at [16n+15:16n] |
| pc | input | 16 | Program counter |
| sp | input | 16 | Stack pointer |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Result valid strobe |
| result | output | 16 | Operand or effective address |
| is_operand | output | 1 | High when `result` is an operand and not an address |
| illegal | output | 1 | Unknown mode code, valid with `done` |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 16 | New stack pointer value |

## Verification
The assertions assume the memory side raises `mem_ack` only while `mem_req` is high, and for a single cycle. They also assume `mode`, `addr_fld`, `reg_sel`, the register contents, `pc` and `sp` are valid whenever `start` is high. The bench drives its memory responder from inside each memory-mode task: it presents one acknowledge cycle after a chosen number of wait cycles. It changes inputs only on falling edges, and it issues `start` outside a pending read except in the one scenario that deliberately probes the ignore rule.

// File: rtl/amu_pkg.sv
package amu_pkg;

    typedef enum logic [3:0] {
        AM_IMM      = 4'd0,
        AM_DIRECT   = 4'd1,
        AM_INDIRECT = 4'd2,
        AM_REG      = 4'd3,
        AM_REG_IND  = 4'd4,
        AM_PC_REL   = 4'd5,
        AM_BASE     = 4'd6,
        AM_INDEXED  = 4'd7,
        AM_PRE_IDX  = 4'd8,
        AM_POST_IDX = 4'd9,
        AM_PUSH     = 4'd10,
        AM_POP      = 4'd11
    } am_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PTR_WAIT = 2'd1,
        ST_RESOLVE  = 2'd2
    } am_state_e;

endpackage

// File: rtl/amu_reg_pick.sv
module amu_reg_pick #(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic [(WORD_W << SEL_W)-1:0] bank,
    input  logic [SEL_W-1:0]             sel,
    output logic [WORD_W-1:0]            value
);
    localparam int NREG = 1 << SEL_W;

    logic [WORD_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign regs[g] = bank[g*WORD_W +: WORD_W];
    end

    assign value = regs[sel];
endmodule

// File: rtl/amu_ea_calc.sv
module amu_ea_calc
    import amu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int FLD_W  = 8
) (
    input  logic [3:0]        mode,
    input  logic [FLD_W-1:0]  afld,
    input  logic [WORD_W-1:0] rval,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] sp,
    output logic [WORD_W-1:0] value,
    output logic              val_is_op,
    output logic              needs_mem,
    output logic              bad_mode,
    output logic              sp_upd,
    output logic [WORD_W-1:0] sp_new,
    output logic [WORD_W-1:0] ptr_addr,
    output logic [WORD_W-1:0] post_add
);
    localparam int EXT_W = WORD_W - FLD_W;

    logic [WORD_W-1:0] fld_sx;
    logic [WORD_W-1:0] fld_zx;

    assign fld_sx = {{EXT_W{afld[FLD_W-1]}}, afld};
    assign fld_zx = {{EXT_W{1'b0}}, afld};

    always_comb begin
        value     = '0;
        val_is_op = 1'b0;
        needs_mem = 1'b0;
        bad_mode  = 1'b0;
        sp_upd    = 1'b0;
        sp_new    = sp;
        ptr_addr  = fld_zx;
        post_add  = '0;
        case (mode)
            AM_IMM: begin
                value     = fld_sx;
                val_is_op = 1'b1;
            end
            AM_DIRECT:   value = fld_zx;
            AM_INDIRECT: needs_mem = 1'b1;
            AM_REG: begin
                value     = rval;
                val_is_op = 1'b1;
            end
            AM_REG_IND:  value = rval;
            AM_PC_REL:   value = pc + fld_sx;
            AM_BASE:     value = rval + fld_sx;
            AM_INDEXED:  value = fld_zx + rval;
            AM_PRE_IDX: begin
                needs_mem = 1'b1;
                ptr_addr  = fld_zx + rval;
            end
            AM_POST_IDX: begin
                needs_mem = 1'b1;
                post_add  = rval;
            end
            AM_PUSH: begin
                value  = sp - 1'b1;
                sp_upd = 1'b1;
                sp_new = sp - 1'b1;
            end
            AM_POP: begin
                value  = sp;
                sp_upd = 1'b1;
                sp_new = sp + 1'b1;
            end
            default: bad_mode = 1'b1;
        endcase
    end
endmodule

// File: rtl/amu_seq.sv
module amu_seq
    import amu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              needs_mem,
    input  logic [WORD_W-1:0] ptr_addr,
    input  logic [WORD_W-1:0] post_add,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              idle,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              fin,
    output logic [WORD_W-1:0] fin_value
);
    am_state_e         state, state_nx;
    logic [WORD_W-1:0] ptr_q, add_q, val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start && needs_mem) state_nx = ST_PTR_WAIT;
            ST_PTR_WAIT: if (mem_ack)            state_nx = ST_RESOLVE;
            ST_RESOLVE:                          state_nx = ST_IDLE;
            default:                             state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            add_q <= '0;
            val_q <= '0;
        end else begin
            if (state == ST_IDLE && start && needs_mem) begin
                ptr_q <= ptr_addr;
                add_q <= post_add;
            end
            if (state == ST_PTR_WAIT && mem_ack)
                val_q <= mem_rdata + add_q;
        end
    end

    always_comb begin
        idle      = 1'b0;
        mem_req   = 1'b0;
        fin       = 1'b0;
        mem_addr  = '0;
        fin_value = val_q;
        unique case (state)
            ST_IDLE:     idle = 1'b1;
            ST_PTR_WAIT: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            ST_RESOLVE:  fin = 1'b1;
            default:     idle = 1'b0;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12
    AST_FIN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> fin); // R3
    AST_FIN_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(mem_req && mem_ack)); // R3
    AST_FIN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !mem_req); // R3
endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
    import amu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int FLD_W  = 8,
    parameter int SEL_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [3:0]                   mode,
    input  logic [FLD_W-1:0]             addr_fld,
    input  logic [SEL_W-1:0]             reg_sel,
    input  logic [(WORD_W << SEL_W)-1:0] reg_bank,
    input  logic [WORD_W-1:0]            pc,
    input  logic [WORD_W-1:0]            sp,
    output logic                         mem_req,
    output logic [WORD_W-1:0]            mem_addr,
    input  logic                         mem_ack,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         done,
    output logic [WORD_W-1:0]            result,
    output logic                         is_operand,
    output logic                         illegal,
    output logic                         sp_we,
    output logic [WORD_W-1:0]            sp_wdata
);
    logic [WORD_W-1:0] rval, value, sp_new, ptr_addr, post_add, fin_value;
    logic val_is_op, needs_mem, bad_mode, sp_upd;
    logic idle, fin, quick;

    amu_reg_pick #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_pick (
        .bank(reg_bank), .sel(reg_sel), .value(rval)
    );

    amu_ea_calc #(.WORD_W(WORD_W), .FLD_W(FLD_W)) u_calc (
        .mode(mode), .afld(addr_fld), .rval(rval), .pc(pc), .sp(sp),
        .value(value), .val_is_op(val_is_op), .needs_mem(needs_mem),
        .bad_mode(bad_mode), .sp_upd(sp_upd), .sp_new(sp_new),
        .ptr_addr(ptr_addr), .post_add(post_add)
    );

    amu_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .needs_mem(needs_mem),
        .ptr_addr(ptr_addr), .post_add(post_add), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .idle(idle), .mem_req(mem_req),
        .mem_addr(mem_addr), .fin(fin), .fin_value(fin_value)
    );

    assign quick      = idle && start && !needs_mem;
    assign done       = quick || fin;
    assign result     = fin ? fin_value : (quick ? value : '0);
    assign is_operand = quick && val_is_op;
    assign illegal    = quick && bad_mode;
    assign sp_we      = quick && sp_upd;
    assign sp_wdata   = sp_new;

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !mem_req && !sp_we)); // R11
    AST_SPWE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (done && !mem_req)); // R9
    AST_OPERAND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        is_operand |-> (done && !mem_req)); // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> !done); // R12
endmodule

// File: tb/sim_addr_mode_unit.sv
module sim_addr_mode_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [7:0]   addr_fld = '0;
    logic [2:0]   reg_sel = '0;
    logic [127:0] reg_bank;
    logic [15:0]  pc = 16'h2000;
    logic [15:0]  sp = 16'h8000;
    logic         mem_req, mem_ack = 1'b0;
    logic [15:0]  mem_addr, mem_rdata = '0;
    logic         done, is_operand, illegal, sp_we;
    logic [15:0]  result, sp_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    addr_mode_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_fld(addr_fld), .reg_sel(reg_sel), .reg_bank(reg_bank),
        .pc(pc), .sp(sp), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .result(result), .is_operand(is_operand), .illegal(illegal),
        .sp_we(sp_we), .sp_wdata(sp_wdata)
    );

    function automatic logic [15:0] regv(int i);
        return 16'((i + 1) * 256 + i);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_now(logic [3:0] m, logic [7:0] a, logic [2:0] s,
                           logic [15:0] exp_res, logic exp_op, logic exp_we,
                           logic [15:0] exp_spw, logic exp_ill, string tag);
        @(negedge clk);
        mode = m; addr_fld = a; reg_sel = s; start = 1'b1;
        #1;
        chk({tag, " done"}, 16'(done), 16'd1);
        chk({tag, " req"}, 16'(mem_req), 16'd0);
        chk({tag, " illegal"}, 16'(illegal), 16'(exp_ill));
        chk({tag, " sp_we"}, 16'(sp_we), 16'(exp_we));
        if (!exp_ill) begin
            chk({tag, " result"}, result, exp_res);
            chk({tag, " is_operand"}, 16'(is_operand), 16'(exp_op));
        end
        if (exp_we) chk({tag, " sp_wdata"}, sp_wdata, exp_spw);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk({tag, " done drop"}, 16'(done), 16'd0);
    endtask

    task automatic run_mem(logic [3:0] m, logic [7:0] a, logic [2:0] s,
                           int lat, logic [15:0] rd, logic [15:0] exp_addr,
                           logic [15:0] exp_ea, bit poke, string tag);
        @(negedge clk);
        mode = m; addr_fld = a; reg_sel = s; start = 1'b1;
        #1;
        chk({tag, " no early done"}, 16'(done), 16'd0);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk({tag, " req"}, 16'(mem_req), 16'd1);
        chk({tag, " addr"}, mem_addr, exp_addr);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (poke && i == 1) begin
                mode = 4'd0; addr_fld = 8'h11; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            #1;
            chk({tag, " req held"}, 16'(mem_req), 16'd1);
            chk({tag, " addr held"}, mem_addr, exp_addr);
            chk({tag, " no done while pending"}, 16'(done), 16'd0);
        end
        @(negedge clk);
        start = 1'b0; mode = m; addr_fld = a;
        mem_ack = 1'b1; mem_rdata = rd;
        #1;
        chk({tag, " done not with ack"}, 16'(done), 16'd0);
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        #1;
        chk({tag, " done after ack"}, 16'(done), 16'd1);
        chk({tag, " ea"}, result, exp_ea);
        chk({tag, " is_operand"}, 16'(is_operand), 16'd0);
        chk({tag, " req dropped"}, 16'(mem_req), 16'd0);
        @(negedge clk);
        #1;
        chk({tag, " single done"}, 16'(done), 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) reg_bank[i*16 +: 16] = regv(i);
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R13 done in reset", 16'(done), 16'd0);
        chk("R13 req in reset", 16'(mem_req), 16'd0);
        chk("R13 sp_we in reset", 16'(sp_we), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R13 done after reset", 16'(done), 16'd0);

        run_now(4'd0, 8'h85, 3'd0, 16'hFF85, 1, 0, 0, 0, "R1 imm neg");
        run_now(4'd0, 8'h7F, 3'd0, 16'h007F, 1, 0, 0, 0, "R1 imm pos");
        run_now(4'd1, 8'h85, 3'd0, 16'h0085, 0, 0, 0, 0, "R2 direct");
        run_now(4'd3, 8'h00, 3'd3, 16'h0403, 1, 0, 0, 0, "R4 register");
        run_now(4'd4, 8'h00, 3'd5, 16'h0605, 0, 0, 0, 0, "R4 reg indirect");
        run_now(4'd5, 8'hF0, 3'd0, 16'h1FF0, 0, 0, 0, 0, "R5 pc rel back");
        run_now(4'd5, 8'h10, 3'd0, 16'h2010, 0, 0, 0, 0, "R5 pc rel fwd");
        run_now(4'd6, 8'hFE, 3'd2, 16'h0300, 0, 0, 0, 0, "R6 base");
        run_now(4'd7, 8'hFE, 3'd2, 16'h0400, 0, 0, 0, 0, "R6 indexed");
        run_now(4'd10, 8'h00, 3'd0, 16'h7FFF, 0, 1, 16'h7FFF, 0, "R9 push");
        run_now(4'd11, 8'h00, 3'd0, 16'h8000, 0, 1, 16'h8001, 0, "R10 pop");
        sp = 16'h0000;
        run_now(4'd10, 8'h00, 3'd0, 16'hFFFF, 0, 1, 16'hFFFF, 0, "R9 push wrap");
        sp = 16'hFFFF;
        run_now(4'd11, 8'h00, 3'd0, 16'hFFFF, 0, 1, 16'h0000, 0, "R10 pop wrap");
        sp = 16'h8000;
        run_now(4'd12, 8'h00, 3'd0, 16'h0000, 0, 0, 0, 1, "R11 code 12");
        run_now(4'd15, 8'h00, 3'd0, 16'h0000, 0, 0, 0, 1, "R11 code 15");

        run_mem(4'd2, 8'h40, 3'd0, 0, 16'hBEEF, 16'h0040, 16'hBEEF, 0, "R3 indirect fast");
        run_mem(4'd2, 8'hC0, 3'd0, 3, 16'h1357, 16'h00C0, 16'h1357, 0, "R3 indirect slow");
        run_mem(4'd8, 8'h40, 3'd1, 1, 16'h1234, 16'h0241, 16'h1234, 0, "R7 preindexed");
        run_mem(4'd9, 8'h40, 3'd1, 2, 16'h1234, 16'h0040, 16'h1435, 0, "R8 postindexed");
        run_mem(4'd2, 8'h22, 3'd0, 4, 16'hCAFE, 16'h0022, 16'hCAFE, 1, "R12 start ignored");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule